// File: doc/BRIEF.md
# Audio Bus-Master Channel Register File

This block holds the programming and status registers for three bus-master audio DMA channels: PCM capture, PCM playback and microphone capture. It also holds one global control register and one global status register. Software reaches every register through a byte-addressed I/O-style port. Each access carries a byte, word or dword width, and its data is right-aligned on the data bus. A read returns its data in the same cycle. A write takes effect on the next rising clock edge.

A DMA engine sits beside the block. It reports buffer completion, last-buffer completion and FIFO error events, and these events set the channel status bits. The engine also loads its current index, prefetch index and remaining sample count through a load strobe. In return it receives the run bits, the descriptor list base addresses and the last valid indices. Each channel combines its status bits with its interrupt enables. The combined condition is shown in the global status register, and a single level interrupt is the OR of the three channel conditions.

Top module: `abm_regfile`

## Requirements
- R1: After reset, every channel register reads zero except channel status, which reads 0x01. Global control reads zero and global status reads 0x0000_0100.
- R2: Channel c (0 to 2) occupies addresses 16*c to 16*c+15, and each register has fixed legal widths:
  - list base: dword at +0
  - current index: byte at +4
  - last valid index: byte at +5, read and write, keeps its low 5 bits
  - status: byte or word at +6
  - remaining count: word at +8
  - prefetch index: byte at +10
  - control: byte at +11

  Global control is a dword at 0x2C and global status is a dword at 0x30. A read at any other address or width returns zero, and a write there changes nothing.
- R3: Status bits are halted (bit 0), last-is-current (bit 1), last-buffer-done (bit 2), buffer-complete (bit 3) and FIFO-error (bit 4). Writing 1 to bits 2, 3 or 4 clears them. Bits 0 and 1 ignore writes. A last-buffer event sets bits 0, 1 and 2, a completion event sets bit 3 and a FIFO event sets bit 4. An event in the same cycle as a clearing write leaves its bit set.
- R4: Control bits are run (bit 0), channel-reset (bit 1), last-buffer interrupt enable (bit 2), FIFO interrupt enable (bit 3) and completion interrupt enable (bit 4). A control write with bit 1 set does three things:
  - it zeroes the list base, current index, last valid index, remaining count and prefetch index
  - it sets status to 0x01, even when an event arrives in the same cycle
  - it keeps the previous values of control bits 2 to 4 and clears bit 0

  Bit 1 always reads 0.
- R5: A channel interrupt is active when status bit 2 and control bit 2 are both set, or when status bit 3 and control bit 4 are both set. While it is active, global status bit 5+c reads 1. `irq_o` is high while any channel interrupt is active, and it falls only after a register write.
- R6: Global control keeps 6 bits. A write with bit 1 or bit 2 set is discarded.
- R7: Global status bits behave as follows:
  - bits 0, 10, 11 and 15 are set by `gs_evt[0..3]` and cleared by writing 1; an event wins over a clear in the same cycle
  - bits 16 and 17 are read and write
  - bit 8 always reads 1
  - bits 5 to 7 follow R5
  - all other bits read 0 and ignore writes
- R8: A dword read at +4 returns current | last<<8 | status<<16. A dword read at +8 returns remaining | prefetch<<16 | control<<24.
- R9: When `eng_ld[c]` is high, the current index, prefetch index and remaining count of channel c take the engine values at the clock edge, unless that channel is being reset in the same cycle.
- R10: `run_o[c]` is control bit 0, `bdbar_o` carries the list base of each channel and `lvi_o` carries the last valid index of each channel. `gctl_o` is global control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Register access valid |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 word, 2 dword |
| acc_addr | input | 6 | Byte address |
| acc_wdata | input | 32 | Right-aligned write data |
| acc_rdata | output | 32 | Right-aligned read data, zero when not reading |
| ev_compl | input | 3 | Buffer-complete event per channel |
| ev_last | input | 3 | Last-buffer event per channel |
| ev_fifo | input | 3 | FIFO error event per channel |
| gs_evt | input | 4 | Set sources for global status bits 0, 10, 11, 15 |
| eng_ld | input | 3 | Engine load strobe per channel |
| eng_civ | input | 3*IDX_W | Current index per channel |
| eng_piv | input | 3*IDX_W | Prefetch index per channel |
| eng_picb | input | 3*PICB_W | Remaining count per channel |
| run_o | output | 3 | Run bit per channel |
| bdbar_o | output | 96 | List base per channel |
| lvi_o | output | 3*IDX_W | Last valid index per channel |
| gctl_o | output | 6 | Global control |
| irq_o | output | 1 | Level interrupt |

## Verification
The bench builds the block with its default parameters: 5-bit indices and a 16-bit remaining count. At that size it can sweep every byte address with all three access widths after each scenario, 192 reads compared against an arithmetic model, so every decode hole and every illegal width is covered. It also writes all 64 values of a 6-bit pattern into a last valid index, which shows the truncation to the index width. Events are applied in the same cycle as clearing writes and channel resets, so the priority rules are exercised rather than assumed.

// File: rtl/abm_pkg.sv
package abm_pkg;
   // access widths
   localparam logic [1:0] SZ_B = 2'd0;
   localparam logic [1:0] SZ_W = 2'd1;
   localparam logic [1:0] SZ_D = 2'd2;

   // per-channel offsets (the packed dword reads depend on these)
   localparam logic [3:0] OFF_BASE = 4'h0;
   localparam logic [3:0] OFF_CUR  = 4'h4;
   localparam logic [3:0] OFF_LAST = 4'h5;
   localparam logic [3:0] OFF_STS  = 4'h6;
   localparam logic [3:0] OFF_REM  = 4'h8;
   localparam logic [3:0] OFF_PRE  = 4'hA;
   localparam logic [3:0] OFF_CTL  = 4'hB;

   localparam logic [5:0] ADDR_GCTL = 6'h2C;
   localparam logic [5:0] ADDR_GSTS = 6'h30;

   // channel status bits
   localparam int STS_W       = 5;
   localparam int ST_HALT     = 0;
   localparam int ST_LASTCUR  = 1;
   localparam int ST_LASTDONE = 2;
   localparam int ST_COMPL    = 3;
   localparam int ST_FIFOERR  = 4;
   localparam logic [STS_W-1:0] ST_W1C   = 5'b11100;
   localparam logic [STS_W-1:0] ST_RESET = 5'b00001;

   // channel control bits
   localparam int CTL_W      = 5;
   localparam int CT_RUN     = 0;
   localparam int CT_RST     = 1;
   localparam int CT_LASTIE  = 2;
   localparam int CT_FIFOIE  = 3;
   localparam int CT_COMPLIE = 4;
   localparam logic [CTL_W-1:0] CT_KEEP = 5'b11100;

   // global registers
   localparam int GC_W    = 6;
   localparam int GC_WARM = 2;
   localparam int GC_COLD = 1;
   localparam int GS_W          = 18;
   localparam int GS_IRQ_LSB    = 5;
   localparam int GS_CODEC_RDY  = 8;
   localparam logic [GS_W-1:0] GS_W1C  = 18'h08C01;
   localparam logic [GS_W-1:0] GS_RW   = 18'h30000;
endpackage

// File: rtl/abm_chan.sv
module abm_chan
   import abm_pkg::*;
#(
   parameter int IDX_W  = 5,
   parameter int PICB_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        off,
   input  logic [1:0]        size,
   input  logic [31:0]       wdata,
   input  logic              ev_compl,
   input  logic              ev_last,
   input  logic              ev_fifo,
   input  logic              ld_en,
   input  logic [IDX_W-1:0]  ld_civ,
   input  logic [IDX_W-1:0]  ld_piv,
   input  logic [PICB_W-1:0] ld_picb,
   output logic [31:0]       rdata,
   output logic              irq,
   output logic              run,
   output logic [31:0]       base_o,
   output logic [IDX_W-1:0]  lvi_o
);
   logic [31:0]       base_q;
   logic [IDX_W-1:0]  civ_q, lvi_q, piv_q;
   logic [PICB_W-1:0] picb_q;
   logic [STS_W-1:0]  sts_q, sts_clr, sts_set, sts_nxt;
   logic [CTL_W-1:0]  ctl_q;
   logic              wr_base, wr_last, wr_sts, wr_ctl, do_rst;
   logic [7:0]        civ_b, lvi_b, piv_b;
   logic [15:0]       picb_h;

   // write decode: field offset and legal width
   assign wr_base = wr_en && (off == OFF_BASE) && (size == SZ_D);
   assign wr_last = wr_en && (off == OFF_LAST) && (size == SZ_B);
   assign wr_sts  = wr_en && (off == OFF_STS) && ((size == SZ_B) || (size == SZ_W));
   assign wr_ctl  = wr_en && (off == OFF_CTL) && (size == SZ_B);
   assign do_rst  = wr_ctl && wdata[CT_RST];

   assign sts_clr = wr_sts ? (wdata[STS_W-1:0] & ST_W1C) : '0;
   assign sts_set = {ev_fifo, ev_compl, ev_last, ev_last, ev_last};
   // events are applied after the clear, so a same-cycle event survives
   assign sts_nxt = (sts_q & ~sts_clr) | sts_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         civ_q  <= '0;
         lvi_q  <= '0;
         piv_q  <= '0;
         picb_q <= '0;
         sts_q  <= ST_RESET;
         ctl_q  <= '0;
      end else if (do_rst) begin
         base_q <= '0;
         civ_q  <= '0;
         lvi_q  <= '0;
         piv_q  <= '0;
         picb_q <= '0;
         sts_q  <= ST_RESET;
         ctl_q  <= ctl_q & CT_KEEP;
      end else begin
         if (wr_base) base_q <= wdata;
         if (wr_last) lvi_q  <= wdata[IDX_W-1:0];
         if (wr_ctl)  ctl_q  <= wdata[CTL_W-1:0];
         sts_q <= sts_nxt;
         if (ld_en) begin
            civ_q  <= ld_civ;
            piv_q  <= ld_piv;
            picb_q <= ld_picb;
         end
      end
   end

   assign civ_b  = 8'(civ_q);
   assign lvi_b  = 8'(lvi_q);
   assign piv_b  = 8'(piv_q);
   assign picb_h = 16'(picb_q);

   // read mux: only a field's legal widths return data
   always_comb begin
      rdata = '0;
      case (off)
         OFF_BASE: if (size == SZ_D) rdata = base_q;
         OFF_CUR: begin
            if (size == SZ_B)      rdata = {24'd0, civ_b};
            else if (size == SZ_D) rdata = {11'd0, sts_q, lvi_b, civ_b};
         end
         OFF_LAST: if (size == SZ_B) rdata = {24'd0, lvi_b};
         OFF_STS:  if ((size == SZ_B) || (size == SZ_W)) rdata = {27'd0, sts_q};
         OFF_REM: begin
            if (size == SZ_W)      rdata = {16'd0, picb_h};
            else if (size == SZ_D) rdata = {3'd0, ctl_q, piv_b, picb_h};
         end
         OFF_PRE: if (size == SZ_B) rdata = {24'd0, piv_b};
         OFF_CTL: if (size == SZ_B) rdata = {27'd0, ctl_q};
         default: rdata = '0;
      endcase
   end

   assign irq    = (sts_q[ST_LASTDONE] && ctl_q[CT_LASTIE]) ||
                   (sts_q[ST_COMPL] && ctl_q[CT_COMPLIE]);
   assign run    = ctl_q[CT_RUN];
   assign base_o = base_q;
   assign lvi_o  = lvi_q;

   // R4: a channel reset leaves halted status, kept enables and cleared indices
   p_chan_reset_r4: assert property (@(posedge clk) disable iff (!rst_n)
      do_rst |=> (sts_q == ST_RESET) && (ctl_q == ($past(ctl_q) & CT_KEEP)) &&
                 (base_q == '0) && (lvi_q == '0) && (civ_q == '0) && (picb_q == '0))
      else $error("p_chan_reset_r4");

   // R3: a clearing write with no event leaves the written 1s cleared
   p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && !ev_fifo && !ev_compl && !ev_last) |=>
         ((sts_q & $past(wdata[STS_W-1:0]) & ST_W1C) == '0))
      else $error("p_w1c_r3");

   // R3: the two read-only status bits ignore status writes
   p_sts_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts && !ev_last) |=> (sts_q[ST_LASTCUR:ST_HALT] == $past(sts_q[ST_LASTCUR:ST_HALT])))
      else $error("p_sts_ro_r3");
endmodule

// File: rtl/abm_glob.sv
module abm_glob
   import abm_pkg::*;
#(
   parameter int NCH = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_gc,
   input  logic            wr_gs,
   input  logic [GS_W-1:0] wdata,
   input  logic [3:0]      gs_evt,
   input  logic [NCH-1:0]  ch_irq,
   output logic [GC_W-1:0] gc_o,
   output logic [31:0]     gs_rd
);
   logic [GC_W-1:0] gc_q;
   logic [GS_W-1:0] gs_q, gs_clr, gs_set, gs_nxt;
   logic            gc_take;

   // a write requesting either codec reset is not stored
   assign gc_take = wr_gc && !wdata[GC_WARM] && !wdata[GC_COLD];

   assign gs_clr = wr_gs ? (wdata & GS_W1C) : '0;
   always_comb begin
      gs_set     = '0;
      gs_set[0]  = gs_evt[0];
      gs_set[10] = gs_evt[1];
      gs_set[11] = gs_evt[2];
      gs_set[15] = gs_evt[3];
   end
   always_comb begin
      gs_nxt = gs_q & ~gs_clr;
      if (wr_gs) gs_nxt = (gs_nxt & ~GS_RW) | (wdata & GS_RW);
      gs_nxt = gs_nxt | gs_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gc_q <= '0;
         gs_q <= '0;
      end else begin
         if (gc_take) gc_q <= wdata[GC_W-1:0];
         gs_q <= gs_nxt;
      end
   end

   always_comb begin
      gs_rd = 32'(gs_q);
      for (int c = 0; c < NCH; c++) gs_rd[GS_IRQ_LSB + c] = ch_irq[c];
      gs_rd[GS_CODEC_RDY] = 1'b1;
   end
   assign gc_o = gc_q;

   // R6: a control write carrying a reset request is discarded
   p_gc_guard_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_gc && (wdata[GC_WARM] || wdata[GC_COLD])) |=> $stable(gc_q))
      else $error("p_gc_guard_r6");

   // R7: stored status moves only on a write or an event
   p_gs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_gs && (gs_evt == 4'd0)) |=> (gs_q == $past(gs_q)))
      else $error("p_gs_hold_r7");
endmodule

// File: rtl/abm_regfile.sv
module abm_regfile
   import abm_pkg::*;
#(
   parameter int NCH    = 3,
   parameter int IDX_W  = 5,
   parameter int PICB_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  acc_en,
   input  logic                  acc_wr,
   input  logic [1:0]            acc_size,
   input  logic [5:0]            acc_addr,
   input  logic [31:0]           acc_wdata,
   output logic [31:0]           acc_rdata,
   input  logic [NCH-1:0]        ev_compl,
   input  logic [NCH-1:0]        ev_last,
   input  logic [NCH-1:0]        ev_fifo,
   input  logic [3:0]            gs_evt,
   input  logic [NCH-1:0]        eng_ld,
   input  logic [NCH*IDX_W-1:0]  eng_civ,
   input  logic [NCH*IDX_W-1:0]  eng_piv,
   input  logic [NCH*PICB_W-1:0] eng_picb,
   output logic [NCH-1:0]        run_o,
   output logic [NCH*32-1:0]     bdbar_o,
   output logic [NCH*IDX_W-1:0]  lvi_o,
   output logic [GC_W-1:0]       gctl_o,
   output logic                  irq_o
);
   localparam int CH_SEL_W = 2;

   initial begin : p_param_chk
      assert (NCH == 3 && IDX_W >= 1 && IDX_W <= 8 && PICB_W >= 1 && PICB_W <= 16)
         else $error("abm_regfile: unsupported parameter set");
   end

   logic [CH_SEL_W-1:0] ch_sel;
   logic [3:0]          off;
   logic                is_gc, is_gs, wr_any, rd_any;
   logic [NCH-1:0]      ch_irq;
   logic [31:0]         ch_rd [NCH];
   logic [31:0]         gs_rd;

   assign ch_sel = acc_addr[5:4];
   assign off    = acc_addr[3:0];
   assign is_gc  = (acc_addr == ADDR_GCTL) && (acc_size == SZ_D);
   assign is_gs  = (acc_addr == ADDR_GSTS) && (acc_size == SZ_D);
   assign wr_any = acc_en && acc_wr;
   assign rd_any = acc_en && !acc_wr;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      abm_chan #(.IDX_W(IDX_W), .PICB_W(PICB_W)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_any && (ch_sel == CH_SEL_W'(c))),
         .off      (off),
         .size     (acc_size),
         .wdata    (acc_wdata),
         .ev_compl (ev_compl[c]),
         .ev_last  (ev_last[c]),
         .ev_fifo  (ev_fifo[c]),
         .ld_en    (eng_ld[c]),
         .ld_civ   (eng_civ[c*IDX_W +: IDX_W]),
         .ld_piv   (eng_piv[c*IDX_W +: IDX_W]),
         .ld_picb  (eng_picb[c*PICB_W +: PICB_W]),
         .rdata    (ch_rd[c]),
         .irq      (ch_irq[c]),
         .run      (run_o[c]),
         .base_o   (bdbar_o[c*32 +: 32]),
         .lvi_o    (lvi_o[c*IDX_W +: IDX_W])
      );
   end

   abm_glob #(.NCH(NCH)) u_glob (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_gc  (wr_any && is_gc),
      .wr_gs  (wr_any && is_gs),
      .wdata  (acc_wdata[GS_W-1:0]),
      .gs_evt (gs_evt),
      .ch_irq (ch_irq),
      .gc_o   (gctl_o),
      .gs_rd  (gs_rd)
   );

   always_comb begin
      acc_rdata = '0;
      if (rd_any) begin
         if (is_gc)      acc_rdata = 32'(gctl_o);
         else if (is_gs) acc_rdata = gs_rd;
         else begin
            for (int c = 0; c < NCH; c++)
               if (ch_sel == CH_SEL_W'(c)) acc_rdata = ch_rd[c];
         end
      end
   end

   assign irq_o = |ch_irq;

   // R5: events only raise interrupts; a drop needs a register write
   p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_o) |-> $past(acc_en && acc_wr))
      else $error("p_irq_fall_r5");
endmodule

// File: tb/test_abm_regfile.sv
module test_abm_regfile;
   localparam int NCH = 3, IW = 5, PW = 16;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic              rst_n;
   logic              acc_en, acc_wr;
   logic [1:0]        acc_size;
   logic [5:0]        acc_addr;
   logic [31:0]       acc_wdata, acc_rdata;
   logic [2:0]        ev_compl, ev_last, ev_fifo, eng_ld;
   logic [3:0]        gs_evt;
   logic [NCH*IW-1:0] eng_civ, eng_piv;
   logic [NCH*PW-1:0] eng_picb;
   logic [2:0]        run_o;
   logic [95:0]       bdbar_o;
   logic [NCH*IW-1:0] lvi_o;
   logic [5:0]        gctl_o;
   logic              irq_o;

   abm_regfile i_abm_regfile (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .ev_compl(ev_compl), .ev_last(ev_last),
      .ev_fifo(ev_fifo), .gs_evt(gs_evt), .eng_ld(eng_ld), .eng_civ(eng_civ),
      .eng_piv(eng_piv), .eng_picb(eng_picb), .run_o(run_o), .bdbar_o(bdbar_o),
      .lvi_o(lvi_o), .gctl_o(gctl_o), .irq_o(irq_o)
   );

   int  n_chk = 0, n_fail = 0;
   bit  done = 0;

   // model state
   logic [31:0] m_base [3];
   logic [7:0]  m_civ [3], m_lvi [3], m_piv [3];
   logic [15:0] m_picb [3];
   logic [4:0]  m_sr [3], m_cr [3];
   logic [5:0]  m_gc;
   logic [31:0] m_gs;

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic m_irq(input int c);
      return (m_sr[c][2] & m_cr[c][2]) | (m_sr[c][3] & m_cr[c][4]);
   endfunction

   function automatic logic [31:0] m_read(input logic [5:0] a, input logic [1:0] s);
      int c;
      logic [3:0] o;
      logic [31:0] g;
      c = int'(a[5:4]);
      o = a[3:0];
      if (a == 6'h2C) return (s == 2) ? {26'd0, m_gc} : 32'd0;
      if (a == 6'h30) begin
         if (s != 2) return 32'd0;
         g = m_gs | 32'h100;
         for (int k = 0; k < 3; k++) if (m_irq(k)) g[5+k] = 1'b1;
         return g;
      end
      if (c == 3) return 32'd0;
      case (o)
         4'h0: return (s == 2) ? m_base[c] : 32'd0;
         4'h4: return (s == 0) ? {24'd0, m_civ[c]} :
                      (s == 2) ? {11'd0, m_sr[c], m_lvi[c], m_civ[c]} : 32'd0;
         4'h5: return (s == 0) ? {24'd0, m_lvi[c]} : 32'd0;
         4'h6: return (s <= 1) ? {27'd0, m_sr[c]} : 32'd0;
         4'h8: return (s == 1) ? {16'd0, m_picb[c]} :
                      (s == 2) ? {3'd0, m_cr[c], m_piv[c], m_picb[c]} : 32'd0;
         4'hA: return (s == 0) ? {24'd0, m_piv[c]} : 32'd0;
         4'hB: return (s == 0) ? {27'd0, m_cr[c]} : 32'd0;
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [5:0] a, input logic [1:0] s);
      if (a == 6'h2C) return "R6";
      if (a == 6'h30) return "R7";
      if ((a[3:0] == 4'h4 || a[3:0] == 4'h8) && s == 2) return "R8";
      if (a[3:0] == 4'h6) return "R3";
      if (a[3:0] == 4'hB) return "R4";
      return "R2";
   endfunction

   task automatic model_reset();
      for (int c = 0; c < 3; c++) begin
         m_base[c] = 0; m_civ[c] = 0; m_lvi[c] = 0; m_piv[c] = 0;
         m_picb[c] = 0; m_sr[c] = 5'h01; m_cr[c] = 0;
      end
      m_gc = 0; m_gs = 0;
   endtask

   // one write/event cycle: inputs held across a single rising edge
   task automatic step(input logic wr_i, input logic [5:0] a, input logic [1:0] s,
                       input logic [31:0] d, input logic [2:0] cpl, input logic [2:0] lst,
                       input logic [2:0] ff, input logic [3:0] ge, input logic [2:0] ld,
                       input logic [7:0] lc, input logic [7:0] lp, input logic [15:0] lpc);
      logic [2:0] rst_c;
      int c;
      @(negedge clk);
      acc_en = wr_i; acc_wr = wr_i; acc_addr = a; acc_size = s; acc_wdata = d;
      ev_compl = cpl; ev_last = lst; ev_fifo = ff; gs_evt = ge; eng_ld = ld;
      eng_civ = {3{lc[4:0]}}; eng_piv = {3{lp[4:0]}}; eng_picb = {3{lpc}};
      rst_c = 3'b000;
      if (wr_i) begin
         c = int'(a[5:4]);
         if (a == 6'h2C && s == 2) begin
            if (!(d[1] || d[2])) m_gc = d[5:0];
         end else if (a == 6'h30 && s == 2) begin
            m_gs = m_gs & ~(d & 32'h8C01);
            m_gs = (m_gs & ~32'h30000) | (d & 32'h30000);
         end else if (c < 3) begin
            if (a[3:0] == 4'h0 && s == 2) m_base[c] = d;
            if (a[3:0] == 4'h5 && s == 0) m_lvi[c] = d[7:0] & 8'h1F;
            if (a[3:0] == 4'h6 && s <= 1) m_sr[c] = m_sr[c] & ~(d[4:0] & 5'h1C);
            if (a[3:0] == 4'hB && s == 0) begin
               if (d[1]) begin
                  rst_c[c] = 1'b1;
                  m_base[c] = 0; m_civ[c] = 0; m_lvi[c] = 0; m_piv[c] = 0;
                  m_picb[c] = 0; m_sr[c] = 5'h01; m_cr[c] = m_cr[c] & 5'h1C;
               end else m_cr[c] = d[4:0];
            end
         end
      end
      for (int k = 0; k < 3; k++) if (!rst_c[k]) begin
         m_sr[k] = m_sr[k] | {ff[k], cpl[k], lst[k], lst[k], lst[k]};
         if (ld[k]) begin
            m_civ[k] = lc & 8'h1F; m_piv[k] = lp & 8'h1F; m_picb[k] = lpc;
         end
      end
      m_gs = m_gs | ({31'd0, ge[0]}) | (32'(ge[1]) << 10) | (32'(ge[2]) << 11) |
             (32'(ge[3]) << 15);
      @(negedge clk);
      acc_en = 0; acc_wr = 0; ev_compl = 0; ev_last = 0; ev_fifo = 0;
      gs_evt = 0; eng_ld = 0;
   endtask

   task automatic wr(input logic [5:0] a, input logic [1:0] s, input logic [31:0] d);
      step(1'b1, a, s, d, 3'd0, 3'd0, 3'd0, 4'd0, 3'd0, 8'd0, 8'd0, 16'd0);
   endtask

   task automatic ports(input string req);
      check("R5", {req, " irq_o"}, 32'(irq_o), 32'(m_irq(0) | m_irq(1) | m_irq(2)));
      for (int c = 0; c < 3; c++) begin
         check("R10", {req, " run_o"}, 32'(run_o[c]), 32'(m_cr[c][0]));
         check("R10", {req, " bdbar_o"}, bdbar_o[c*32 +: 32], m_base[c]);
         check("R10", {req, " lvi_o"}, 32'(lvi_o[c*IW +: IW]), 32'(m_lvi[c]));
      end
      check("R10", {req, " gctl_o"}, 32'(gctl_o), 32'(m_gc));
   endtask

   // full address/width sweep against the model
   task automatic sweep(input string what);
      for (int a = 0; a < 64; a++) begin
         for (int s = 0; s < 3; s++) begin
            @(negedge clk);
            acc_en = 1; acc_wr = 0; acc_addr = 6'(a); acc_size = 2'(s);
            #1;
            check(tag_of(6'(a), 2'(s)),
                  $sformatf("%s read a=%02h s=%0d", what, a, s),
                  acc_rdata, m_read(6'(a), 2'(s)));
            acc_en = 0;
         end
      end
      ports(what);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 0; acc_en = 0; acc_wr = 0; acc_size = 0; acc_addr = 0; acc_wdata = 0;
      ev_compl = 0; ev_last = 0; ev_fifo = 0; gs_evt = 0; eng_ld = 0;
      eng_civ = 0; eng_piv = 0; eng_picb = 0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1 reset state
      sweep("R1 reset");

      // R2 list bases, illegal widths ignored
      wr(6'h00, 2'd2, 32'hA5A5_0001);
      wr(6'h10, 2'd2, 32'h1234_5678);
      wr(6'h20, 2'd2, 32'hDEAD_BEEF);
      wr(6'h00, 2'd1, 32'hFFFF_FFFF);
      wr(6'h10, 2'd0, 32'h0000_00FF);
      wr(6'h14, 2'd2, 32'hFFFF_FFFF);
      wr(6'h18, 2'd2, 32'hFFFF_FFFF);
      wr(6'h2C, 2'd0, 32'h0000_0039);
      sweep("R2 bases");

      // R2 last valid index truncation, all 64 patterns
      for (int v = 0; v < 64; v++) begin
         wr(6'h15, 2'd0, 32'(v));
         check("R2", "lvi truncation", 32'(lvi_o[IW +: IW]), 32'(v & 31));
      end

      // R4/R10 control store, RR never stored
      wr(6'h0B, 2'd0, 32'h0000_0015);
      wr(6'h1B, 2'd0, 32'h0000_0011);
      wr(6'h2B, 2'd0, 32'h0000_0009);
      sweep("R4 control");

      // R5 last-buffer event on ch0 raises irq; R3 RO bits ignore writes
      step(1'b0, 0, 0, 0, 3'd0, 3'b001, 3'd0, 4'd0, 3'd0, 0, 0, 0);
      check("R5", "irq after last event", 32'(irq_o), 32'd1);
      wr(6'h06, 2'd0, 32'h0000_0003);
      sweep("R3 ro bits");
      // R3 clear with same-cycle event: event wins
      step(1'b1, 6'h06, 2'd1, 32'h1C, 3'd0, 3'b001, 3'd0, 4'd0, 3'd0, 0, 0, 0);
      sweep("R3 set wins");
      wr(6'h06, 2'd0, 32'h0000_001F);
      check("R5", "irq drop after clear", 32'(irq_o), 32'd0);
      sweep("R3 cleared");

      // R5 completion on ch1, FIFO on ch2 (no interrupt path)
      step(1'b0, 0, 0, 0, 3'b010, 3'd0, 3'b100, 4'd0, 3'd0, 0, 0, 0);
      sweep("R5 completion");
      wr(6'h16, 2'd1, 32'h0000_0008);
      sweep("R5 cleared");

      // R9 engine load on ch0 and ch2
      step(1'b0, 0, 0, 0, 3'd0, 3'd0, 3'd0, 4'd0, 3'b101, 8'h3B, 8'h07, 16'hBEEF);
      sweep("R9 load");

      // R4 channel reset with same-cycle events and load on ch0
      step(1'b1, 6'h0B, 2'd0, 32'h0000_0002, 3'b011, 3'b011, 3'b001, 4'd0, 3'b001,
           8'h11, 8'h12, 16'h1313);
      sweep("R4 reset");

      // R6 global control
      wr(6'h2C, 2'd2, 32'h0000_003B);
      wr(6'h2C, 2'd2, 32'h0000_0039);
      wr(6'h2C, 2'd2, 32'h0000_003D);
      sweep("R6 gctl");

      // R7 global status
      step(1'b0, 0, 0, 0, 3'd0, 3'd0, 3'd0, 4'b1111, 3'd0, 0, 0, 0);
      wr(6'h30, 2'd2, 32'hFFFC_73FE);
      sweep("R7 rw/ro");
      step(1'b1, 6'h30, 2'd2, 32'h0000_8C01, 3'd0, 3'd0, 3'd0, 4'b0101, 3'd0, 0, 0, 0);
      sweep("R7 clear");
      wr(6'h30, 2'd2, 32'h0001_8C01);
      sweep("R7 final");

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule